// File: doc/BRIEF.md
# Configuration Bit-File Header Parser

This block takes the byte stream of an FPGA configuration file and walks its tagged header until it reaches the configuration payload. The file opens with a preamble: a 16-bit length, that many bytes that are thrown away, and a second 16-bit length. After the preamble comes a run of tagged records. Four string records carry the design name, the part name, the date and the time. Each has a 16-bit length followed by its characters. The block latches each string length and forwards the characters on a side output, marked with a field code. All multi-byte lengths arrive most significant byte first.

When the payload tag arrives, the block latches its 32-bit length and emits a one-cycle start strobe. It then passes every following byte straight through to a downstream loader. While the loader is not accepting bytes, the byte input is back-pressured.

The parser raises a done flag once the whole payload has been handed on. An unrecognised tag aborts parsing with a tag error. An end-of-stream marker seen too early aborts parsing with a truncation error. After done or either error, the input stays closed until reset.

Top module: `cfg_stream_hdr_parser`

## Requirements
- R1: After a synchronous active-low reset, `in_ready` is 1, and `pay_done`, `err_tag`, `err_trunc`, `pay_start`, `pay_len` and all four string lengths are 0.
- R2: The preamble is parsed as follows. First comes a big-endian 16-bit length N. Then N bytes are discarded, whatever their values, and N may be 0. Then a second big-endian 16-bit length is consumed. Only after that is a tag byte expected.
- R3: The tag bytes 0x61, 0x62, 0x63 and 0x64 each introduce a string record with a big-endian 16-bit length. That length is latched on `len_design`, `len_part`, `len_date` or `len_time` respectively. The records may come in any order, and a length of 0 is allowed.
- R4: Each character byte of a string record is presented on `str_data` with `str_valid` high. `str_field` marks the record: 0 for design, 1 for part, 2 for date, 3 for time. No other byte raises `str_valid`.
- R5: Tag byte 0x65 introduces the payload with a big-endian 32-bit length. The length appears on `pay_len`, and `pay_start` is high for exactly one cycle. That cycle is the one after the last length byte is accepted.
- R6: Payload bytes pass to `pay_data` unchanged and in order, with `pay_valid` following `in_valid`. During the payload, `in_ready` equals `pay_ready`.
- R7: `pay_done` rises in the cycle after the last payload byte is accepted. For a zero-length payload, it rises together with `pay_start`. It then stays high, with `in_ready` low, until reset.
- R8: Any other byte in tag position sets `err_tag`. After that, `in_ready`, `str_valid` and `pay_valid` stay low until reset.
- R9: An accepted byte with `in_last` high, before the payload is complete, sets `err_trunc`. This applies in the header and in the payload. After that, `in_ready` stays low and `pay_done` stays 0. `in_last` on the final payload byte is not an error.
- R10: A reset in the middle of a stream returns the parser to the preamble. It clears all latched lengths and flags, and a new file then parses normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte valid |
| in_last | input | 1 | Marks the final byte of the stream |
| in_ready | output | 1 | Parser accepts the stream byte |
| str_data | output | 8 | String character byte |
| str_valid | output | 1 | String byte present |
| str_field | output | 2 | String field code (0 design, 1 part, 2 date, 3 time) |
| len_design | output | 16 | Latched design-name length |
| len_part | output | 16 | Latched part-name length |
| len_date | output | 16 | Latched date length |
| len_time | output | 16 | Latched time length |
| pay_len | output | 32 | Latched payload length |
| pay_start | output | 1 | One-cycle strobe when payload begins |
| pay_data | output | 8 | Payload byte to the loader |
| pay_valid | output | 1 | Payload byte present |
| pay_ready | input | 1 | Loader accepts a payload byte |
| pay_done | output | 1 | Whole payload handed on (sticky) |
| err_tag | output | 1 | Unknown tag seen (sticky) |
| err_trunc | output | 1 | Stream ended early (sticky) |

## Verification
The assertions assume that the stream obeys the handshake: `in_data` and `in_last` do not change while `in_valid` is high and `in_ready` is low. They also assume that `pay_ready` is driven on every cycle, including outside the payload.

The stimulus changes inputs only on the falling clock edge. It samples `in_ready` just before the rising edge, and it holds a byte until that byte is accepted. After done or an error, it never offers another byte.

Back-pressure is applied through a fixed pattern on `pay_ready`. Truncation is produced only through `in_last`.

// File: rtl/csh_pkg.sv
// Package: shared state encoding and tag constants for the configuration
// bit-file header parser. Assumes 8-bit stream bytes.
package csh_pkg;
    typedef enum logic [3:0] {
        S_LEN0,  // first preamble length
        S_SKIP,  // discarded preamble bytes
        S_LEN1,  // second preamble length
        S_TAG,   // record tag byte
        S_SLEN,  // string record length
        S_STR,   // string characters
        S_PLEN,  // payload length
        S_PAY,   // payload pass-through
        S_DONE,  // payload complete
        S_ERR    // aborted
    } csh_state_e;

    localparam logic [7:0] TAG_STR_FIRST = 8'h61;
    localparam logic [7:0] TAG_PAYLOAD   = 8'h65;
endpackage

// File: rtl/csh_be_accum.sv
// Module: big-endian length accumulator. Each accepted byte shifts in at the
// bottom, so after K shifts the low 8*K bits hold a K-byte big-endian value.
// Assumes the caller only reads as many low bits as bytes it shifted in.
module csh_be_accum #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic [7:0]   din,
    output logic [W-1:0] acc_nxt
);
    logic [W-1:0] acc_q;

    // Next value with the incoming byte as the least significant byte.
    assign acc_nxt = {acc_q[W-9:0], din};

    // Shift register holding the bytes collected so far.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc_q <= '0;
        else if (shift) acc_q <= acc_nxt;
    end
endmodule

// File: rtl/csh_down_cnt.sv
// Module: loadable down counter for record bodies (skip, string, payload).
// Assumes the controller never loads and decrements in the same cycle, and
// never loads zero into a body it will walk.
module csh_down_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_one
);
    logic [W-1:0] cnt_q;

    // Remaining byte count of the current record body.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - 1'b1;
    end

    // Flags the last byte of the body.
    assign is_one = (cnt_q == W'(1));

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q != '0)); // R6
endmodule

// File: rtl/cfg_stream_hdr_parser.sv
// Module: configuration bit-file header parser (top). It walks the preamble
// and the tagged records, latches the string and payload lengths, forwards
// string bytes with a field code, and passes the payload to a loader.
// Assumes a valid/ready input where data is held until accepted, and a loader
// that drives pay_ready on every cycle.
module cfg_stream_hdr_parser
    import csh_pkg::*;
#(
    parameter int HDR_LEN_W  = 16,
    parameter int PAY_LEN_W  = 32,
    parameter int NUM_FIELDS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           in_data,
    input  logic                 in_valid,
    input  logic                 in_last,
    output logic                 in_ready,
    output logic [7:0]           str_data,
    output logic                 str_valid,
    output logic [1:0]           str_field,
    output logic [HDR_LEN_W-1:0] len_design,
    output logic [HDR_LEN_W-1:0] len_part,
    output logic [HDR_LEN_W-1:0] len_date,
    output logic [HDR_LEN_W-1:0] len_time,
    output logic [PAY_LEN_W-1:0] pay_len,
    output logic                 pay_start,
    output logic [7:0]           pay_data,
    output logic                 pay_valid,
    input  logic                 pay_ready,
    output logic                 pay_done,
    output logic                 err_tag,
    output logic                 err_trunc
);
    localparam int HDR_BYTES = HDR_LEN_W / 8;
    localparam int PAY_BYTES = PAY_LEN_W / 8;
    localparam int IDX_W     = $clog2(PAY_BYTES);
    localparam int FLD_W     = $clog2(NUM_FIELDS);
    localparam logic [7:0] TAG_STR_LAST = TAG_STR_FIRST + 8'(NUM_FIELDS - 1);

    csh_state_e           state_q, state_n;
    logic [IDX_W-1:0]     idx_q;
    logic [FLD_W-1:0]     field_q;
    logic [HDR_LEN_W-1:0] fld_len_q [NUM_FIELDS];
    logic [PAY_LEN_W-1:0] pay_len_q;
    logic                 start_q, err_tag_q, err_trunc_q;

    logic                 fire, in_len, len_last, len_done, cnt_one;
    logic                 tag_str, tag_bad, trunc, cnt_load, cnt_dec;
    logic [PAY_LEN_W-1:0] acc_nxt, cnt_val;
    logic [HDR_LEN_W-1:0] hdr_val;

    assign fire     = in_valid & in_ready;
    assign in_len   = (state_q == S_LEN0) || (state_q == S_LEN1) ||
                      (state_q == S_SLEN) || (state_q == S_PLEN);
    assign len_last = (state_q == S_PLEN) ? (idx_q == IDX_W'(PAY_BYTES - 1))
                                          : (idx_q == IDX_W'(HDR_BYTES - 1));
    assign len_done = fire && in_len && len_last;
    assign hdr_val  = acc_nxt[HDR_LEN_W-1:0];
    assign tag_str  = (in_data >= TAG_STR_FIRST) && (in_data <= TAG_STR_LAST);

    csh_be_accum #(.W(PAY_LEN_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .shift(fire && in_len),
        .din(in_data), .acc_nxt(acc_nxt)
    );

    assign cnt_load = len_done && (state_q != S_LEN1);
    assign cnt_val  = (state_q == S_PLEN) ? acc_nxt : PAY_LEN_W'(hdr_val);
    assign cnt_dec  = fire && ((state_q == S_SKIP) || (state_q == S_STR) ||
                               (state_q == S_PAY));

    csh_down_cnt #(.W(PAY_LEN_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
        .dec(cnt_dec), .is_one(cnt_one)
    );

    // Next-state decode of the tag/length walk, including both abort paths.
    always_comb begin
        state_n = state_q;
        tag_bad = 1'b0;
        unique case (state_q)
            S_LEN0: if (len_done) state_n = (hdr_val == '0) ? S_LEN1 : S_SKIP;
            S_SKIP: if (fire && cnt_one) state_n = S_LEN1;
            S_LEN1: if (len_done) state_n = S_TAG;
            S_TAG:  if (fire) begin
                        if (tag_str)                   state_n = S_SLEN;
                        else if (in_data == TAG_PAYLOAD) state_n = S_PLEN;
                        else begin state_n = S_ERR; tag_bad = 1'b1; end
                    end
            S_SLEN: if (len_done) state_n = (hdr_val == '0) ? S_TAG : S_STR;
            S_STR:  if (fire && cnt_one) state_n = S_TAG;
            S_PLEN: if (len_done) state_n = (acc_nxt == '0) ? S_DONE : S_PAY;
            S_PAY:  if (fire && cnt_one) state_n = S_DONE;
            default: state_n = state_q;
        endcase
        trunc = fire && in_last && !tag_bad && (state_n != S_DONE);
        if (trunc) state_n = S_ERR;
    end

    // State, byte index within a length field, and current string field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_LEN0;
            idx_q   <= '0;
            field_q <= '0;
        end else begin
            state_q <= state_n;
            if (len_done)           idx_q <= '0;
            else if (fire && in_len) idx_q <= idx_q + 1'b1;
            if (fire && state_q == S_TAG && tag_str)
                field_q <= FLD_W'(in_data - TAG_STR_FIRST);
        end
    end

    // Payload length, start strobe and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pay_len_q   <= '0;
            start_q     <= 1'b0;
            err_tag_q   <= 1'b0;
            err_trunc_q <= 1'b0;
        end else begin
            start_q <= len_done && (state_q == S_PLEN);
            if (len_done && state_q == S_PLEN) pay_len_q <= acc_nxt;
            if (tag_bad) err_tag_q   <= 1'b1;
            if (trunc)   err_trunc_q <= 1'b1;
        end
    end

    // One length register per string field.
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
        always_ff @(posedge clk) begin
            if (!rst_n) fld_len_q[g] <= '0;
            else if (len_done && state_q == S_SLEN && field_q == FLD_W'(g))
                fld_len_q[g] <= hdr_val;
        end
    end

    assign len_design = fld_len_q[0];
    assign len_part   = fld_len_q[1];
    assign len_date   = fld_len_q[2];
    assign len_time   = fld_len_q[3];

    // Input readiness: follows the loader during the payload, closed at the end.
    always_comb begin
        unique case (state_q)
            S_PAY:         in_ready = pay_ready;
            S_DONE, S_ERR: in_ready = 1'b0;
            default:       in_ready = 1'b1;
        endcase
    end

    assign str_data  = in_data;
    assign str_valid = (state_q == S_STR) && in_valid;
    assign str_field = 2'(field_q);
    assign pay_data  = in_data;
    assign pay_valid = (state_q == S_PAY) && in_valid;
    assign pay_len   = pay_len_q;
    assign pay_start = start_q;
    assign pay_done  = (state_q == S_DONE);
    assign err_tag   = err_tag_q;
    assign err_trunc = err_trunc_q;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pay_start |=> !pay_start); // R5
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pay_done |=> pay_done); // R7
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_tag || err_trunc) |=> (err_tag || err_trunc)); // R8
    AST_CLOSED_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_done || err_tag || err_trunc) |-> (!in_ready && !str_valid && !pay_valid)); // R8
    AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(pay_done && (err_tag || err_trunc))); // R9
    AST_STR_NOT_PAY: assert property (@(posedge clk) disable iff (!rst_n)
        !(str_valid && pay_valid)); // R4
    AST_READY_FOLLOWS_LOADER: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> (in_ready == pay_ready)); // R6
endmodule

// File: tb/cfg_stream_hdr_parser_tb_top.sv
// Bench: directed scenarios, one task each, checking results at the ports.
module cfg_stream_hdr_parser_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic in_valid = 1'b0, in_last = 1'b0, pay_ready = 1'b1;
    logic in_ready, str_valid, pay_start, pay_valid, pay_done, err_tag, err_trunc;
    logic [7:0] str_data, pay_data;
    logic [1:0] str_field;
    logic [15:0] len_design, len_part, len_date, len_time;
    logic [31:0] pay_len;

    int checks = 0, errors = 0, cycles = 0;
    byte unsigned q[$], exp_str[$], exp_pay[$], got_str[$], got_pay[$];
    int exp_fld[$], got_fld[$];
    int start_cnt = 0, rdy_mis = 0, bpc = 0;
    logic [31:0] len_at_start = '0;
    bit bp_en = 0;

    cfg_stream_hdr_parser dut_i (.*);

    always #4 clk = ~clk;

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Start-strobe monitor, sampled on the falling edge.
    always @(negedge clk) if (pay_start) begin start_cnt++; len_at_start = pay_len; end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; in_valid = 0; in_last = 0; pay_ready = 1;
        repeat (2) @(negedge clk);
        rst_n = 1;
        q.delete(); exp_str.delete(); exp_pay.delete(); exp_fld.delete();
        got_str.delete(); got_pay.delete(); got_fld.delete();
        start_cnt = 0; rdy_mis = 0; bp_en = 0;
    endtask

    task automatic add16(int v); q.push_back(8'(v >> 8)); q.push_back(8'(v)); endtask
    task automatic add32(int v);
        for (int i = 3; i >= 0; i--) q.push_back(8'(v >> (8 * i)));
    endtask
    task automatic add_pre(int skip);
        add16(skip);
        for (int i = 0; i < skip; i++) q.push_back(8'(8'h65 + i));
        add16(1);
    endtask
    task automatic add_str(byte unsigned tag, string s);
        q.push_back(tag); add16(s.len());
        for (int i = 0; i < s.len(); i++) begin
            q.push_back(s[i]); exp_str.push_back(s[i]); exp_fld.push_back(tag - 8'h61);
        end
    endtask
    task automatic add_pay(int n, int keep);
        q.push_back(8'h65); add32(n);
        for (int i = 0; i < keep; i++) begin
            q.push_back(8'(i * 7 + 3)); exp_pay.push_back(8'(i * 7 + 3));
        end
    endtask

    // Offer one byte and hold it until accepted; capture side outputs.
    task automatic drive_byte(byte unsigned b, bit last);
        bit ok;
        @(negedge clk);
        in_data = b; in_valid = 1; in_last = last;
        do begin
            if (bp_en) begin bpc++; pay_ready = (bpc % 3) != 0; end
            #1;
            ok = in_ready;
            if (pay_valid && in_ready !== pay_ready) rdy_mis++;
            if (ok && str_valid) begin got_str.push_back(str_data); got_fld.push_back(str_field); end
            if (ok && pay_valid) got_pay.push_back(pay_data);
            @(posedge clk);
            if (!ok) @(negedge clk);
        end while (!ok);
    endtask

    task automatic send_all(bit last_on_end);
        for (int i = 0; i < q.size(); i++) drive_byte(q[i], last_on_end && (i == q.size() - 1));
        @(negedge clk); in_valid = 0; in_last = 0; pay_ready = 1;
        #1;
    endtask

    task automatic cmp_captures(string rs, string rp);
        int bad = 0;
        chk(rs, got_str.size(), exp_str.size());
        foreach (exp_str[i]) if (i < got_str.size())
            if (got_str[i] != exp_str[i] || got_fld[i] != exp_fld[i]) bad++;
        chk(rs, bad, 0);
        bad = 0;
        chk(rp, got_pay.size(), exp_pay.size());
        foreach (exp_pay[i]) if (i < got_pay.size() && got_pay[i] != exp_pay[i]) bad++;
        chk(rp, bad, 0);
    endtask

    task automatic t_reset();
        do_reset(); #1;
        chk("R1 in_ready", in_ready, 1);
        chk("R1 flags", {pay_done, err_tag, err_trunc, pay_start}, 0);
        chk("R1 lengths", len_design | len_part | len_date | len_time, 0);
        chk("R1 pay_len", pay_len, 0);
    endtask

    task automatic t_full();
        do_reset();
        add_pre(4);
        add_str(8'h61, "top"); add_str(8'h62, "xc_part"); add_str(8'h63, "2024/01/01");
        add_str(8'h64, "12:34:56"); add_pay(6, 6);
        send_all(1);
        chk("R2/R3 len_design", len_design, 3);
        chk("R3 len_part", len_part, 7);
        chk("R3 len_date", len_date, 10);
        chk("R3 len_time", len_time, 8);
        cmp_captures("R4 string bytes", "R6 payload bytes");
        chk("R5 start pulses", start_cnt, 1);
        chk("R5 pay_len", len_at_start, 6);
        chk("R7 done", pay_done, 1);
        chk("R7 ready closed", in_ready, 0);
        chk("R9 no error", {err_tag, err_trunc}, 0);
    endtask

    task automatic t_backpressure();
        do_reset(); bp_en = 1;
        add_pre(2); add_str(8'h62, "p"); add_pay(20, 20);
        send_all(0);
        cmp_captures("R4 bp strings", "R6 bp payload");
        chk("R6 ready follows loader", rdy_mis, 0);
        chk("R7 done after bp", pay_done, 1);
    endtask

    task automatic t_zero_and_order();
        do_reset();
        add_pre(0); add_str(8'h64, ""); add_str(8'h62, "ab"); add_pay(0, 0);
        send_all(1);
        chk("R2 zero skip / R3 len_part", len_part, 2);
        chk("R3 zero len_time", len_time, 0);
        chk("R3 untouched len_design", len_design, 0);
        cmp_captures("R4 reordered strings", "R6 empty payload");
        chk("R7 zero-length done", pay_done, 1);
        chk("R5 zero-length start", start_cnt, 1);
        chk("R9 last on final length ok", err_trunc, 0);
    endtask

    task automatic t_unknown();
        do_reset();
        add_pre(3); add_str(8'h61, "x"); q.push_back(8'h7a);
        send_all(0);
        chk("R8 err_tag", err_tag, 1);
        chk("R8 ready closed", in_ready, 0);
        chk("R8 no trunc", err_trunc, 0);
        chk("R8 len kept", len_design, 1);
        chk("R8 no start", start_cnt, 0);
        @(negedge clk); in_valid = 1; in_data = 8'h65; #1;
        chk("R8 no output after error", {str_valid, pay_valid, in_ready}, 0);
        @(negedge clk); in_valid = 0;
    endtask

    task automatic t_trunc();
        do_reset();
        add_pre(1); add_pay(6, 3);
        send_all(1);
        chk("R9 payload trunc", err_trunc, 1);
        chk("R9 no done", pay_done, 0);
        chk("R9 ready closed", in_ready, 0);
        chk("R9 bytes before trunc", got_pay.size(), 3);
        do_reset();
        add_pre(1); q.push_back(8'h61); add16(5); q.push_back(8'h41); q.push_back(8'h42);
        send_all(1);
        chk("R9 header trunc", err_trunc, 1);
        chk("R9 header trunc chars", got_str.size(), 2);
    endtask

    task automatic t_midreset();
        do_reset();
        add_pre(2); add_str(8'h63, "d1"); add_pay(6, 2);
        send_all(0);
        chk("R10 pre-reset pay_len", pay_len, 6);
        do_reset(); #1;
        chk("R10 lengths cleared", {len_date, pay_len[15:0]}, 0);
        chk("R10 flags cleared", {pay_done, err_tag, err_trunc}, 0);
        chk("R10 ready", in_ready, 1);
        add_pre(1); add_str(8'h61, "abcd"); add_pay(2, 2);
        send_all(1);
        chk("R10 reparse len", len_design, 4);
        chk("R10 reparse done", pay_done, 1);
    endtask

    initial begin
        t_reset();
        t_full();
        t_backpressure();
        t_zero_and_order();
        t_unknown();
        t_trunc();
        t_midreset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule